// File: doc/BRIEF.md
# Coin-Paid Call Supervisor

This block supervises a single paid telephone call from start to finish. It watches the receiver hook, a coin-accepted pulse, two line-status flags (busy and connected), a line-fault flag and a one-second tick. From these it drives four outputs: a refund strobe, a call-enable level, a top-up prompt and an out-of-order indication.

A caller first lifts the receiver and then pays one coin. After that the line either reports busy or connects. On a busy line, hanging up returns the coin. A connected call is billed in periods of 60 seconds. The prompt for another coin comes up once 45 seconds of the current period have elapsed. A coin paid while the prompt is up starts a fresh period. If no coin arrives, the call is cut off when the 60th second ends. A line fault takes priority over every other condition. Recovery from a fault needs both a clear fault flag and the receiver on the hook.

Top module: `paycall_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in its idle state with all four outputs low.
- R2: With the receiver lifted but no coin paid, a connected line does not raise call_en.
- R3: Once the receiver is lifted and a coin is paid, a connected line raises call_en in the cycle after the cycle in which line_conn is seen.
- R4: Hanging up after a coin is paid, before the line connects (while waiting or on a busy line), makes coin_ret high for exactly one cycle: the cycle in which on_hook is high. The output is combinational.
- R5: During a connected call, coin_prompt is high exactly while 45 or more ticks have been counted in the current period. call_en stays high while the prompt is shown.
- R6: The 60th tick of a period with no top-up coin drops call_en and coin_prompt in the next cycle.
- R7: A coin paid while coin_prompt is high starts a new period at zero ticks. The prompt goes low in the next cycle, and the next cut-off is 60 ticks after that coin.
- R8: A coin paid during a call before the prompt window has no effect: the prompt still comes at tick 45 of the original period.
- R9: Hanging up during a connected call, or after a cut-off, never produces coin_ret, and it drops call_en.
- R10: After a cut-off, no new call can start until the receiver has been back on the hook: coins and a connected line are ignored while it stays lifted.
- R11: line_fault high in any state raises out_of_order in the next cycle. While out_of_order is high, call_en, coin_prompt and coin_ret are low.
- R12: The block leaves the out-of-order state, back to idle, only in a cycle where line_fault is low and on_hook is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_hook | input | 1 | 1 = receiver resting on the hook |
| coin_pulse | input | 1 | One-cycle pulse per accepted coin |
| line_busy | input | 1 | Called line reports busy |
| line_conn | input | 1 | Called line has connected |
| line_fault | input | 1 | Line fault present |
| sec_tick | input | 1 | One-cycle pulse every second |
| coin_ret | output | 1 | Refund strobe |
| call_en | output | 1 | Call path enabled |
| coin_prompt | output | 1 | Ask the caller for another coin |
| out_of_order | output | 1 | Block is in the fault state |

## Verification
The bench walks through a full billing period tick by tick. It checks that the prompt appears exactly at tick 45 and the cut-off at tick 60; a counter that is off by one would shift either edge by one cycle. An early coin that wrongly restarted the period would delay the prompt past tick 45. A top-up that failed to restart the period would cut the call short. A design that refunds on every hang-up would strobe coin_ret when a connected call ends. A design that leaves the fault state as soon as the flag clears would drop out_of_order while the receiver is still lifted.

// File: rtl/paycall_pkg.sv
package paycall_pkg;

    localparam int unsigned DEF_PERIOD_S = 60;
    localparam int unsigned DEF_PROMPT_S = 45;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LIFTED  = 3'd1,
        ST_PAID    = 3'd2,
        ST_BUSY    = 3'd3,
        ST_TALK    = 3'd4,
        ST_ENDED   = 3'd5,
        ST_FAULT   = 3'd6
    } call_state_t;

    typedef struct packed {
        logic refund;
        logic talk;
        logic prompt;
        logic oos;
    } call_out_t;

    function automatic logic holds_unused_coin(call_state_t s);
        return (s == ST_PAID) || (s == ST_BUSY);
    endfunction

endpackage

// File: rtl/paycall_timer.sv
module paycall_timer #(
    parameter int unsigned PERIOD_S = 60,
    localparam int unsigned CNT_W   = $clog2(PERIOD_S + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R6: the count never runs past the last second of a period
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(PERIOD_S - 1));

endmodule

// File: rtl/paycall_fsm.sv
module paycall_fsm
    import paycall_pkg::*;
#(
    parameter int unsigned PERIOD_S = 60,
    parameter int unsigned PROMPT_S = 45,
    localparam int unsigned CNT_W   = $clog2(PERIOD_S + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on_hook,
    input  logic             coin,
    input  logic             busy,
    input  logic             conn,
    input  logic             fault,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output call_out_t        outs
);

    call_state_t state_q, state_d;
    logic        in_window, last_sec, restart;

    assign in_window = (cnt >= CNT_W'(PROMPT_S));
    assign last_sec  = (cnt == CNT_W'(PERIOD_S - 1));

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        if (fault) begin
            state_d = ST_FAULT;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (!on_hook) state_d = ST_LIFTED;
                ST_LIFTED: begin
                    if (on_hook)   state_d = ST_IDLE;
                    else if (coin) state_d = ST_PAID;
                end
                ST_PAID: begin
                    if (on_hook)   state_d = ST_IDLE;
                    else if (conn) state_d = ST_TALK;
                    else if (busy) state_d = ST_BUSY;
                end
                ST_BUSY:   if (on_hook) state_d = ST_IDLE;
                ST_TALK: begin
                    if (on_hook)                  state_d = ST_IDLE;
                    else if (coin && in_window)   restart = 1'b1;
                    else if (tick && last_sec)    state_d = ST_ENDED;
                end
                ST_ENDED:  if (on_hook) state_d = ST_IDLE;
                ST_FAULT:  if (on_hook) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign cnt_clr = restart || (state_q != ST_TALK) || (state_d != ST_TALK);
    assign cnt_inc = (state_q == ST_TALK) && tick;

    always_comb begin
        outs.refund = holds_unused_coin(state_q) && on_hook && !fault;
        outs.talk   = (state_q == ST_TALK);
        outs.prompt = (state_q == ST_TALK) && in_window;
        outs.oos    = (state_q == ST_FAULT);
    end

    p_ret_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        outs.refund |=> !outs.refund);

    p_fault_ooo_r11: assert property (@(posedge clk) disable iff (rst)
        fault |=> outs.oos);

    p_ooo_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        outs.oos |-> !(outs.talk || outs.prompt || outs.refund));

    p_prompt_in_call_r5: assert property (@(posedge clk) disable iff (rst)
        outs.prompt |-> outs.talk);

    p_call_offhook_r2: assert property (@(posedge clk) disable iff (rst)
        outs.talk |-> !$past(on_hook));

    p_topup_r7: assert property (@(posedge clk) disable iff (rst)
        (outs.prompt && coin && !on_hook && !fault) |=> (outs.talk && !outs.prompt));

    p_cut_r6: assert property (@(posedge clk) disable iff (rst)
        (outs.talk && tick && last_sec && !coin && !on_hook && !fault) |=> !outs.talk);

    p_no_refund_talk_r9: assert property (@(posedge clk) disable iff (rst)
        outs.talk |-> !outs.refund);

endmodule

// File: rtl/paycall_ctrl.sv
module paycall_ctrl
    import paycall_pkg::*;
#(
    parameter int unsigned PERIOD_S = DEF_PERIOD_S,
    parameter int unsigned PROMPT_S = DEF_PROMPT_S
) (
    input  logic clk,
    input  logic rst,
    input  logic on_hook,
    input  logic coin_pulse,
    input  logic line_busy,
    input  logic line_conn,
    input  logic line_fault,
    input  logic sec_tick,
    output logic coin_ret,
    output logic call_en,
    output logic coin_prompt,
    output logic out_of_order
);

    localparam int unsigned CNT_W = $clog2(PERIOD_S + 1);

    logic [CNT_W-1:0] sec_cnt;
    logic             cnt_clr, cnt_inc;
    call_out_t        outs;

    paycall_timer #(.PERIOD_S(PERIOD_S)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (sec_cnt)
    );

    paycall_fsm #(.PERIOD_S(PERIOD_S), .PROMPT_S(PROMPT_S)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .on_hook (on_hook),
        .coin    (coin_pulse),
        .busy    (line_busy),
        .conn    (line_conn),
        .fault   (line_fault),
        .tick    (sec_tick),
        .cnt     (sec_cnt),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .outs    (outs)
    );

    assign coin_ret     = outs.refund;
    assign call_en      = outs.talk;
    assign coin_prompt  = outs.prompt;
    assign out_of_order = outs.oos;

endmodule

// File: tb/paycall_ctrl_bench.sv
`timescale 1ns/100ps
module paycall_ctrl_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_hook = 1'b1, coin_pulse = 1'b0, line_busy = 1'b0;
    logic line_conn = 1'b0, line_fault = 1'b0, sec_tick = 1'b0;
    logic coin_ret, call_en, coin_prompt, out_of_order;

    always #2.5 clk = ~clk;

    paycall_ctrl u_paycall_ctrl (
        .clk(clk), .rst(rst), .on_hook(on_hook), .coin_pulse(coin_pulse),
        .line_busy(line_busy), .line_conn(line_conn), .line_fault(line_fault),
        .sec_tick(sec_tick), .coin_ret(coin_ret), .call_en(call_en),
        .coin_prompt(coin_prompt), .out_of_order(out_of_order)
    );

    // expected vector = {coin_ret, call_en, coin_prompt, out_of_order}
    logic [3:0] q_exp[$];
    string      q_tag[$];
    int n_run = 0, n_fail = 0, n_cyc = 0;
    bit done = 1'b0;
    logic [3:0] m_exp, m_got;
    string      m_tag;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor: compares once the driver's inputs for this cycle have settled
    always @(negedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            m_exp = q_exp.pop_front();
            m_tag = q_tag.pop_front();
            m_got = {coin_ret, call_en, coin_prompt, out_of_order};
            n_run++;
            if (m_got !== m_exp) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", m_tag, m_got, m_exp);
            end
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    // driver: one call = one clock cycle of stimulus plus optional expectation
    task automatic step(input logic h, input logic c, input logic b, input logic n,
                        input logic f, input logic t, input bit chk,
                        input logic [3:0] e, input string tag);
        @(negedge clk);
        on_hook = h; coin_pulse = c; line_busy = b;
        line_conn = n; line_fault = f; sec_tick = t;
        if (chk) begin
            q_exp.push_back(e);
            q_tag.push_back(tag);
        end
    endtask

    task automatic run_ticks(input int cnt, input int start, input string tag);
        for (int k = 0; k < cnt; k++) begin
            step(0, 0, 0, 1, 0, 1, 1, {1'b0, 1'b1, (start + k) >= 45, 1'b0}, tag);
        end
    endtask

    task automatic start_call();
        step(0, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        step(0, 1, 0, 0, 0, 0, 0, 4'b0000, "");
        step(0, 0, 0, 1, 0, 0, 0, 4'b0000, "");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0100, "R3 connected call");
    endtask

    initial begin
        rst = 1'b1;
        step(1, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        step(1, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        @(negedge clk); rst = 1'b0;
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R1 after reset");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R1 idle");

        // R2: lifted, no coin, line connects -> no call
        step(0, 0, 0, 0, 0, 0, 1, 4'b0000, "R2 lift");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R2 no coin");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R2 no coin");
        step(0, 1, 0, 1, 0, 0, 1, 4'b0000, "R2 coin cycle");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R3 paid waiting");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0100, "R3 call enabled");
        // R5/R6: full period without top-up
        run_ticks(60, 0, "R5 period tick");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R6 cut off");
        // R10: still lifted, coin and connect ignored
        step(0, 1, 0, 1, 0, 0, 1, 4'b0000, "R10 coin after cut");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R10 no restart");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0000, "R10 no restart");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R9 hang up after cut, no refund");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R9 idle");

        // R4: busy line refund
        step(0, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        step(0, 1, 0, 0, 0, 0, 0, 4'b0000, "");
        step(0, 0, 1, 0, 0, 0, 1, 4'b0000, "R4 paid");
        step(0, 0, 1, 0, 0, 0, 1, 4'b0000, "R4 busy");
        step(1, 0, 1, 0, 0, 0, 1, 4'b1000, "R4 refund on hang up");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R4 refund one cycle");
        // R4: hang up before any line status
        step(0, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        step(0, 1, 0, 0, 0, 0, 0, 4'b0000, "");
        step(1, 0, 0, 0, 0, 0, 1, 4'b1000, "R4 refund while waiting");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R4 refund ended");

        // R8/R7/R9: early coin ignored, top-up restarts, hang up no refund
        start_call();
        run_ticks(10, 0, "R8 before coin");
        step(0, 1, 0, 1, 0, 0, 1, 4'b0100, "R8 early coin");
        run_ticks(35, 10, "R8 period unchanged");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0110, "R5 prompt at 45");
        step(0, 1, 0, 1, 0, 0, 1, 4'b0110, "R7 top-up coin");
        step(0, 0, 0, 1, 0, 0, 1, 4'b0100, "R7 prompt cleared");
        run_ticks(59, 0, "R7 new period");
        step(1, 0, 0, 1, 0, 0, 1, 4'b0110, "R9 hang up mid call");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R9 no refund after call");

        // R11/R12: fault from idle
        step(1, 0, 0, 0, 1, 0, 1, 4'b0000, "R11 fault seen");
        step(1, 0, 0, 0, 1, 0, 1, 4'b0001, "R11 out of order");
        step(0, 0, 0, 0, 0, 0, 1, 4'b0001, "R12 cleared but lifted");
        step(0, 0, 0, 0, 0, 0, 1, 4'b0001, "R12 stays out of order");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0001, "R12 leaving");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R12 back to idle");
        // R11: fault during a call
        start_call();
        run_ticks(3, 0, "R11 call running");
        step(0, 0, 0, 1, 1, 0, 1, 4'b0100, "R11 fault in call");
        step(1, 0, 0, 1, 1, 0, 1, 4'b0001, "R11 call dropped");
        step(1, 0, 0, 0, 1, 0, 1, 4'b0001, "R12 fault still set");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0001, "R12 exit cycle");
        step(1, 0, 0, 0, 0, 0, 1, 4'b0000, "R12 idle again");

        step(1, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        step(1, 0, 0, 0, 0, 0, 0, 4'b0000, "");
        @(negedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            summary();
        end
    end

endmodule